// File: doc/BRIEF.md
# Dual Saturating Accumulator Unit

This block holds two 40-bit signed accumulators and one shared 40-bit adder/subtracter. Each accepted operation names one accumulator. That accumulator is both the first adder input and the destination of the result. The operation can add a 40-bit operand, subtract it, load it, clear the accumulator or negate the accumulator. The upper eight bits are guard bits above a 32-bit (1.31) working range.

Each result is checked for two kinds of overflow: a spill into the guard bits, and a true overflow of the full 40-bit signed range. A per-accumulator saturation enable and a shared width select choose one of three regimes: clamp at the 40-bit limits, clamp at the 32-bit limits, or wrap with no clamp. For each accumulator the block keeps a guard-overflow flag and a sticky saturation flag, plus OR-combined copies of each. It raises trap requests that a separate interrupt controller services.

Operations arrive on a valid/ready port. `op_ready` is held high at all times. The unit never applies back-pressure, so every cycle with `op_valid` high is one accepted operation.

Top module: `dual_sat_acc`

## Requirements
- R1: When `op_valid` is high, the accumulator picked by `op_sel` (0 = A, 1 = B) is written at the next rising edge, and the other accumulator keeps its value. The value written is the one `op_code` selects, with 0 = add operand, 1 = subtract operand, 2 = load operand, 3 = clear to zero and 4 = negate accumulator, treated as 40-bit two's complement and then passed through R4 to R6.
- R2: `op_ready` is always 1. In a cycle with `op_valid` low, neither accumulator and neither guard-overflow flag changes.
- R3: On each accepted operation, the selected accumulator's guard-overflow flag (`ovf_a`/`ovf_b`) takes the value 1 exactly when bits 39..32 of the stored result are not all equal. The only exception is R5.
- R4: With saturation enabled and `sat_mode`=0, a result beyond the 40-bit signed range stores 0x7FFFFFFFFF if the true sum is positive and 0x8000000000 if it is negative. That accumulator's sticky flag is then set.
- R5: With saturation enabled and `sat_mode`=1, a result outside the 32-bit signed range stores 0x007FFFFFFF or 0xFF80000000 according to the true sign, and sets the sticky flag. In this regime the guard-overflow flag is always written 0.
- R6: With saturation disabled for the selected accumulator, the 40-bit result wraps. A 40-bit signed overflow then sets that accumulator's sticky flag (a catastrophic overflow).
- R7: Sticky flags are set only by hardware. `sticky_clr_a` and `sticky_clr_b` clear one flag each, and `sticky_clr_all` clears both. A set in the same cycle wins over a clear.
- R8: `ovf_any` is the OR of the two guard-overflow flags, and `sat_any` is the OR of the two sticky flags.
- R9: `trap_ovf_a`/`trap_ovf_b` are high while the matching guard flag and trap enable are both high. `trap_cat` is high for the one cycle after an accepted catastrophic overflow (R6) while `cat_trap_en` is high.
- R10: After reset, both accumulators and all flags and trap outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Operation accepted (always 1) |
| op_code | input | 3 | Operation: 0 add, 1 sub, 2 load, 3 clear, 4 negate |
| op_sel | input | 1 | Target accumulator: 0 = A, 1 = B |
| op_data | input | 40 | Operand for add, sub and load |
| sat_en_a | input | 1 | Saturation enable for A |
| sat_en_b | input | 1 | Saturation enable for B |
| sat_mode | input | 1 | 0 = 40-bit clamp, 1 = 32-bit clamp |
| ovf_trap_en_a | input | 1 | Trap enable for A guard overflow |
| ovf_trap_en_b | input | 1 | Trap enable for B guard overflow |
| cat_trap_en | input | 1 | Trap enable for catastrophic overflow |
| sticky_clr_a | input | 1 | Clear A sticky flag |
| sticky_clr_b | input | 1 | Clear B sticky flag |
| sticky_clr_all | input | 1 | Clear both sticky flags |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| ovf_a | output | 1 | A guard-overflow flag |
| ovf_b | output | 1 | B guard-overflow flag |
| sat_a | output | 1 | A sticky saturation flag |
| sat_b | output | 1 | B sticky saturation flag |
| ovf_any | output | 1 | OR of guard-overflow flags |
| sat_any | output | 1 | OR of sticky flags |
| trap_ovf_a | output | 1 | Trap request, A guard overflow |
| trap_ovf_b | output | 1 | Trap request, B guard overflow |
| trap_cat | output | 1 | Trap request, catastrophic overflow |

## Verification
An accepted operation, and any sticky clear, shows its effect on the accumulators, the flags and `trap_cat` one cycle later, after exactly one register. The guard-overflow traps and the OR flags follow those registers with no further delay, and they also follow the enables in the same cycle. The bench drives its inputs just after a falling edge. It steps its reference model at the rising edge and compares every output at the next falling edge. Every result is therefore checked in the first cycle it is due, and never again after a later operation has overwritten it.

// File: rtl/dual_sat_acc_pkg.sv
package dual_sat_acc_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_LOAD = 3'd2,
    OP_CLR  = 3'd3,
    OP_NEG  = 3'd4
  } acc_op_e;

  localparam int NUM_ACC = 2;
endpackage

// File: rtl/acc_addsub.sv
module acc_addsub
  import dual_sat_acc_pkg::*;
#(
  parameter int W = 40
) (
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd,
  input  acc_op_e      op,
  output logic [W-1:0] sum,
  output logic         ovf_top,
  output logic         carry_top
);
  logic [W-1:0] lhs, rhs;
  logic         cin;
  logic [W-1:0] low;
  logic [1:0]   top;

  // operand steering: one side may be zero, the other true or complemented
  always_comb begin
    lhs = acc_in;
    rhs = opnd;
    cin = 1'b0;
    unique case (op)
      OP_ADD:  begin lhs = acc_in;    rhs = opnd;    cin = 1'b0; end
      OP_SUB:  begin lhs = acc_in;    rhs = ~opnd;   cin = 1'b1; end
      OP_LOAD: begin lhs = '0;        rhs = opnd;    cin = 1'b0; end
      OP_CLR:  begin lhs = '0;        rhs = '0;      cin = 1'b0; end
      OP_NEG:  begin lhs = '0;        rhs = ~acc_in; cin = 1'b1; end
      default: begin lhs = acc_in;    rhs = opnd;    cin = 1'b0; end
    endcase
  end

  // split adder exposing carry into and out of the top bit
  always_comb begin
    low = {1'b0, lhs[W-2:0]} + {1'b0, rhs[W-2:0]} + {{(W-1){1'b0}}, cin};
    top = {1'b0, lhs[W-1]} + {1'b0, rhs[W-1]} + {1'b0, low[W-1]};
    sum       = {top[0], low[W-2:0]};
    carry_top = top[1];
    ovf_top   = top[1] ^ low[W-1];
  end
endmodule

// File: rtl/acc_saturate.sv
module acc_saturate #(
  parameter int W     = 40,
  parameter int LOW_W = 32
) (
  input  logic [W-1:0] raw,
  input  logic         ovf_top,
  input  logic         carry_top,
  input  logic         sat_en,
  input  logic         mode_low,
  output logic [W-1:0] res,
  output logic         guard_ovf,
  output logic         sticky_set,
  output logic         cat_evt
);
  localparam int HI_W = W - LOW_W + 1;
  localparam logic [W-1:0] FULL_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] FULL_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] LOW_POS  = {{HI_W{1'b0}}, {(LOW_W-1){1'b1}}};
  localparam logic [W-1:0] LOW_NEG  = {{HI_W{1'b1}}, {(LOW_W-1){1'b0}}};

  logic [HI_W-1:0] hi_bits;
  logic            low_out;
  logic            true_neg;

  always_comb begin
    hi_bits  = raw[W-1:LOW_W-1];
    low_out  = ovf_top | ~((&hi_bits) | ~(|hi_bits));
    true_neg = ovf_top ? carry_top : raw[W-1];
  end

  always_comb begin
    res        = raw;
    sticky_set = 1'b0;
    cat_evt    = 1'b0;
    if (!sat_en) begin
      sticky_set = ovf_top;
      cat_evt    = ovf_top;
    end else if (mode_low) begin
      if (low_out) begin
        res        = true_neg ? LOW_NEG : LOW_POS;
        sticky_set = 1'b1;
      end
    end else if (ovf_top) begin
      res        = carry_top ? FULL_NEG : FULL_POS;
      sticky_set = 1'b1;
    end
  end

  always_comb begin
    if (sat_en && mode_low) guard_ovf = 1'b0;
    else guard_ovf = ~((&res[W-1:LOW_W]) | ~(|res[W-1:LOW_W]));
  end
endmodule

// File: rtl/acc_bank.sv
module acc_bank #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] nxt_val,
  input  logic         nxt_guard,
  input  logic         sticky_set,
  input  logic         sticky_clr,
  output logic [W-1:0] acc_q,
  output logic         guard_q,
  output logic         sticky_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      guard_q <= 1'b0;
    end else if (we) begin
      acc_q   <= nxt_val;
      guard_q <= nxt_guard;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky_q <= 1'b0;
    else if (sticky_set) sticky_q <= 1'b1;
    else if (sticky_clr) sticky_q <= 1'b0;
  end

  // R2: an idle bank keeps its value
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (acc_q == $past(acc_q)) && (guard_q == $past(guard_q)));

  // R7: a set request wins over a simultaneous clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_set |=> sticky_q);
endmodule

// File: rtl/dual_sat_acc.sv
module dual_sat_acc
  import dual_sat_acc_pkg::*;
#(
  parameter int ACC_W   = 40,
  parameter int GUARD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [2:0]       op_code,
  input  logic             op_sel,
  input  logic [ACC_W-1:0] op_data,
  input  logic             sat_en_a,
  input  logic             sat_en_b,
  input  logic             sat_mode,
  input  logic             ovf_trap_en_a,
  input  logic             ovf_trap_en_b,
  input  logic             cat_trap_en,
  input  logic             sticky_clr_a,
  input  logic             sticky_clr_b,
  input  logic             sticky_clr_all,
  output logic [ACC_W-1:0] acc_a,
  output logic [ACC_W-1:0] acc_b,
  output logic             ovf_a,
  output logic             ovf_b,
  output logic             sat_a,
  output logic             sat_b,
  output logic             ovf_any,
  output logic             sat_any,
  output logic             trap_ovf_a,
  output logic             trap_ovf_b,
  output logic             trap_cat
);
  localparam int LOW_W = ACC_W - GUARD_W;
  localparam logic [ACC_W-1:0] FULL_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] FULL_NEG = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] acc_q   [NUM_ACC];
  logic             guard_q [NUM_ACC];
  logic             sticky_q[NUM_ACC];
  logic [NUM_ACC-1:0] sat_en_v, clr_v, trap_en_v;

  logic [ACC_W-1:0] cur_acc, raw_sum, sat_res;
  logic             add_ovf, add_carry, sel_sat_en;
  logic             nxt_guard, nxt_sticky, cat_now;
  logic             cat_q;

  assign op_ready  = 1'b1;
  assign sat_en_v  = {sat_en_b, sat_en_a};
  assign clr_v     = {sticky_clr_b, sticky_clr_a};
  assign trap_en_v = {ovf_trap_en_b, ovf_trap_en_a};

  assign cur_acc    = acc_q[op_sel];
  assign sel_sat_en = sat_en_v[op_sel];

  acc_addsub #(.W(ACC_W)) u_addsub (
    .acc_in    (cur_acc),
    .opnd      (op_data),
    .op        (acc_op_e'(op_code)),
    .sum       (raw_sum),
    .ovf_top   (add_ovf),
    .carry_top (add_carry)
  );

  acc_saturate #(.W(ACC_W), .LOW_W(LOW_W)) u_sat (
    .raw        (raw_sum),
    .ovf_top    (add_ovf),
    .carry_top  (add_carry),
    .sat_en     (sel_sat_en),
    .mode_low   (sat_mode),
    .res        (sat_res),
    .guard_ovf  (nxt_guard),
    .sticky_set (nxt_sticky),
    .cat_evt    (cat_now)
  );

  for (genvar i = 0; i < NUM_ACC; i++) begin : g_bank
    logic hit;
    assign hit = op_valid && (op_sel == 1'(i));
    acc_bank #(.W(ACC_W)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .we         (hit),
      .nxt_val    (sat_res),
      .nxt_guard  (nxt_guard),
      .sticky_set (hit && nxt_sticky),
      .sticky_clr (clr_v[i] || sticky_clr_all),
      .acc_q      (acc_q[i]),
      .guard_q    (guard_q[i]),
      .sticky_q   (sticky_q[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cat_q <= 1'b0;
    else cat_q <= op_valid && cat_now;
  end

  assign acc_a      = acc_q[0];
  assign acc_b      = acc_q[1];
  assign ovf_a      = guard_q[0];
  assign ovf_b      = guard_q[1];
  assign sat_a      = sticky_q[0];
  assign sat_b      = sticky_q[1];
  assign ovf_any    = guard_q[0] | guard_q[1];
  assign sat_any    = sticky_q[0] | sticky_q[1];
  assign trap_ovf_a = guard_q[0] & trap_en_v[0];
  assign trap_ovf_b = guard_q[1] & trap_en_v[1];
  assign trap_cat   = cat_q & cat_trap_en;

  // R4: a full-range overflow under 40-bit clamping lands on a limit
  p_full_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && sel_sat_en && !sat_mode && add_ovf |=>
      (($past(op_sel) ? acc_b : acc_a) == FULL_POS) ||
      (($past(op_sel) ? acc_b : acc_a) == FULL_NEG));

  // R5: the 32-bit regime never leaves a guard flag set on its target
  p_guard_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && sel_sat_en && sat_mode |=> ($past(op_sel) ? !ovf_b : !ovf_a));

  // R6: a sticky flag only rises after an operation on that accumulator
  p_sticky_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sat_a) |-> $past(op_valid && !op_sel));

  // R7: a clear-all with no operation empties both sticky flags
  p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_clr_all && !op_valid |=> !sat_a && !sat_b);

  // R9: a catastrophic trap needs a wrapped overflow one cycle earlier
  p_cat_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_cat |-> $past(op_valid && !sel_sat_en && add_ovf));
endmodule

// File: tb/dual_sat_acc_tb.sv
module dual_sat_acc_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 0, op_sel = 0, sat_en_a = 0, sat_en_b = 0, sat_mode = 0;
  logic ovf_trap_en_a = 0, ovf_trap_en_b = 0, cat_trap_en = 0;
  logic sticky_clr_a = 0, sticky_clr_b = 0, sticky_clr_all = 0;
  logic [2:0]  op_code = 0;
  logic [39:0] op_data = 0;
  logic op_ready, ovf_a, ovf_b, sat_a, sat_b, ovf_any, sat_any;
  logic trap_ovf_a, trap_ovf_b, trap_cat;
  logic [39:0] acc_a, acc_b;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dual_sat_acc u_dut (.*);

  // reference model state
  logic [39:0] m_acc[2];
  bit m_ovf[2], m_sat[2], m_cat;

  localparam longint MAX40 = 64'sd549755813887;
  localparam longint MIN40 = -64'sd549755813888;
  localparam longint MAX32 = 64'sd2147483647;
  localparam longint MIN32 = -64'sd2147483648;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin m_acc[i] = '0; m_ovf[i] = 0; m_sat[i] = 0; end
      m_cat = 0;
    end else begin
      longint a, d, t;
      logic [39:0] v;
      bit ov, se, st, ct;
      int s;
      if (sticky_clr_a || sticky_clr_all) m_sat[0] = 0;
      if (sticky_clr_b || sticky_clr_all) m_sat[1] = 0;
      ct = 0;
      if (op_valid) begin
        s = op_sel ? 1 : 0;
        a = longint'($signed(m_acc[s]));
        d = longint'($signed(op_data));
        case (op_code)
          3'd0: t = a + d;
          3'd1: t = a - d;
          3'd2: t = d;
          3'd3: t = 0;
          default: t = -a;
        endcase
        ov = (t > MAX40) || (t < MIN40);
        se = s ? sat_en_b : sat_en_a;
        st = 0;
        v = t[39:0];
        if (!se) begin st = ov; ct = ov; end
        else if (sat_mode) begin
          if (t > MAX32) begin v = 40'h007FFFFFFF; st = 1; end
          else if (t < MIN32) begin v = 40'hFF80000000; st = 1; end
        end else begin
          if (t > MAX40) begin v = 40'h7FFFFFFFFF; st = 1; end
          else if (t < MIN40) begin v = 40'h8000000000; st = 1; end
        end
        m_acc[s] = v;
        m_ovf[s] = (se && sat_mode) ? 0 : !(v[39:32] == 8'h00 || v[39:32] == 8'hFF);
        if (st) m_sat[s] = 1;
      end
      m_cat = ct;
    end
  end

  task automatic chk(string req, string nm, logic [39:0] act, logic [39:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R1", "acc_a", acc_a, m_acc[0]);
    chk("R1", "acc_b", acc_b, m_acc[1]);
    chk("R2", "op_ready", 40'(op_ready), 40'd1);
    chk("R3", "ovf_a", 40'(ovf_a), 40'(m_ovf[0]));
    chk("R3", "ovf_b", 40'(ovf_b), 40'(m_ovf[1]));
    chk("R6", "sat_a", 40'(sat_a), 40'(m_sat[0]));
    chk("R6", "sat_b", 40'(sat_b), 40'(m_sat[1]));
    chk("R8", "ovf_any", 40'(ovf_any), 40'(m_ovf[0] | m_ovf[1]));
    chk("R8", "sat_any", 40'(sat_any), 40'(m_sat[0] | m_sat[1]));
    chk("R9", "trap_ovf_a", 40'(trap_ovf_a), 40'(m_ovf[0] & ovf_trap_en_a));
    chk("R9", "trap_ovf_b", 40'(trap_ovf_b), 40'(m_ovf[1] & ovf_trap_en_b));
    chk("R9", "trap_cat", 40'(trap_cat), 40'(m_cat & cat_trap_en));
  endtask

  task automatic do_op(logic [2:0] code, logic sel, logic [39:0] data);
    op_valid = 1; op_code = code; op_sel = sel; op_data = data;
    @(negedge clk);
    op_valid = 0;
    compare_all();
  endtask

  task automatic idle();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset values
    chk("R10", "acc_a reset", acc_a, 40'h0);
    chk("R10", "acc_b reset", acc_b, 40'h0);
    chk("R10", "flags reset", 40'({ovf_a, ovf_b, sat_a, sat_b, trap_cat}), 40'h0);
    rst_n = 1;
    idle();

    // R1: each operation, A and B
    do_op(3'd2, 0, 40'h0000001234);
    chk("R1", "load A", acc_a, 40'h0000001234);
    do_op(3'd0, 0, 40'h0000000010);
    chk("R1", "add A", acc_a, 40'h0000001244);
    do_op(3'd2, 1, 40'h0000000005);
    do_op(3'd1, 1, 40'h0000000008);
    chk("R1", "sub B", acc_b, 40'hFFFFFFFFFD);
    chk("R1", "A untouched", acc_a, 40'h0000001244);
    do_op(3'd4, 1, 40'h0);
    chk("R1", "neg B", acc_b, 40'h0000000003);
    // R2: idle cycles change nothing
    op_data = 40'hFFFFFFFFFF; idle(); idle();
    chk("R2", "idle A", acc_a, 40'h0000001244);

    // R3 and R4: 40-bit clamp
    sat_en_a = 1; sat_mode = 0; ovf_trap_en_a = 1;
    do_op(3'd2, 0, 40'h7FFFFFFFFF);
    chk("R3", "guard set", 40'(ovf_a), 40'd1);
    chk("R9", "trap A", 40'(trap_ovf_a), 40'd1);
    do_op(3'd0, 0, 40'h0000000001);
    chk("R4", "pos clamp", acc_a, 40'h7FFFFFFFFF);
    chk("R4", "sticky A", 40'(sat_a), 40'd1);
    do_op(3'd2, 0, 40'h8000000000);
    do_op(3'd1, 0, 40'h0000000001);
    chk("R4", "neg clamp", acc_a, 40'h8000000000);
    do_op(3'd4, 0, 40'h0);
    chk("R4", "neg of min", acc_a, 40'h7FFFFFFFFF);

    // R5: 32-bit clamp on B
    sat_en_b = 1; sat_mode = 1;
    do_op(3'd2, 1, 40'h007FFFFFF0);
    do_op(3'd0, 1, 40'h0000000100);
    chk("R5", "pos low clamp", acc_b, 40'h007FFFFFFF);
    chk("R5", "guard quiet", 40'(ovf_b), 40'd0);
    chk("R5", "sticky B", 40'(sat_b), 40'd1);
    do_op(3'd2, 1, 40'hFF80000000);
    do_op(3'd1, 1, 40'h0000000001);
    chk("R5", "neg low clamp", acc_b, 40'hFF80000000);

    // R7: clears
    sticky_clr_a = 1; idle(); sticky_clr_a = 0;
    chk("R7", "clr A", 40'({sat_a, sat_b}), 40'b01);
    sticky_clr_all = 1; idle(); sticky_clr_all = 0;
    chk("R7", "clr all", 40'({sat_a, sat_b}), 40'b00);

    // R6 and R9: wrap with catastrophic trap
    sat_en_a = 0; cat_trap_en = 1; sat_mode = 0;
    do_op(3'd2, 0, 40'h7FFFFFFFFF);
    do_op(3'd0, 0, 40'h0000000001);
    chk("R6", "wrap", acc_a, 40'h8000000000);
    chk("R6", "cat sticky", 40'(sat_a), 40'd1);
    chk("R9", "cat trap", 40'(trap_cat), 40'd1);
    idle();
    chk("R9", "cat trap pulse", 40'(trap_cat), 40'd0);
    // R7: set beats clear
    sticky_clr_all = 1;
    do_op(3'd0, 0, 40'h8000000000);
    sticky_clr_all = 0;
    chk("R7", "set wins", 40'(sat_a), 40'd1);

    // random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [39:0] dv;
      int pick;
      pick = $urandom_range(0, 5);
      case (pick)
        0: dv = 40'h7FFFFFFFFF;
        1: dv = 40'h8000000000;
        2: dv = 40'h0080000000;
        3: dv = {{8{1'b0}}, 32'($urandom)};
        default: dv = {8'($urandom), 32'($urandom)};
      endcase
      if ($urandom_range(0, 15) == 0) begin
        sat_en_a = 1'($urandom); sat_en_b = 1'($urandom); sat_mode = 1'($urandom);
        ovf_trap_en_a = 1'($urandom); ovf_trap_en_b = 1'($urandom); cat_trap_en = 1'($urandom);
      end
      sticky_clr_a   = ($urandom_range(0, 19) == 0);
      sticky_clr_b   = ($urandom_range(0, 19) == 0);
      sticky_clr_all = ($urandom_range(0, 39) == 0);
      if ($urandom_range(0, 3) != 0)
        do_op(3'($urandom_range(0, 4)), 1'($urandom), dv);
      else begin
        op_data = dv; idle();
      end
      sticky_clr_a = 0; sticky_clr_b = 0; sticky_clr_all = 0;
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule